// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver Slice

This block passes data between an A port and a B port in both directions. Each direction has its own storage element, and that element runs in one of three modes. In transparent mode the output follows the input in the same cycle. In latched mode the stored word stays fixed. In clocked mode a rising edge of a per-direction strobe loads a new word. One latch-enable and one clock strobe per direction pick the mode.

The whole slice sits in a single system clock domain. The strobes are sampled as ordinary inputs, and each clock strobe is compared with its value from the previous system cycle to find rising edges. Each direction also has an output enable. The two enables have opposite polarities: A-to-B is active high and B-to-A is active low. Tri-state pins are replaced by an output bus plus a drive flag per port. While a port is not driven, its output bus shows a keeper value, which is the last word the port actually drove. Several slices can be placed side by side to build wider buses.

Top module: `regBusXcvr`

## Requirements
- R1: While `abLatchEn` is 1 and `bDrive` is 1, `bOut` equals `aIn` in the same cycle.
- R2: While `abLatchEn` is 0 and no rising edge of `abClk` is seen, the stored A-to-B word does not change. It appears on `bOut` whenever `bDrive` is 1.
- R3: When `abLatchEn` is 0 and `abClk` is 1 in a cycle where it was 0 in the previous cycle, `aIn` of that cycle is stored at the clock edge and appears on `bOut` from the next cycle on.
- R4: When `abLatchEn` falls and `abClk` does not rise, the stored word is the `aIn` value of the last cycle in which `abLatchEn` was 1.
- R5: The B-to-A direction obeys R1 to R4 with `baLatchEn`, `baClk`, `bIn` and `aOut` in place of the A-to-B signals. It works independently of the A-to-B direction.
- R6: `bDrive` equals `abOutEn`, which is active high. `aDrive` equals the inverse of `baOutEnN`, which is active low.
- R7: While a port's drive flag is 0, its output bus shows the value it drove at the last clock edge at which its drive flag was 1.
- R8: A synchronous active-high `rst` clears both stored words, both keeper values and both edge detectors to zero.
- R9: `contention` is 1 exactly when `aDrive` and `bDrive` are both 1.
- R10: A clock strobe held at 1 for several cycles loads only once, in the first cycle it is seen at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| aIn | input | WIDTH | Data arriving on the A side |
| bIn | input | WIDTH | Data arriving on the B side |
| abLatchEn | input | 1 | A-to-B transparent select |
| abClk | input | 1 | A-to-B load strobe, rising edge |
| abOutEn | input | 1 | B-side output enable, active high |
| baLatchEn | input | 1 | B-to-A transparent select |
| baClk | input | 1 | B-to-A load strobe, rising edge |
| baOutEnN | input | 1 | A-side output enable, active low |
| aOut | output | WIDTH | Data driven on the A side, or the A keeper value |
| aDrive | output | 1 | A side is actively driven |
| bOut | output | WIDTH | Data driven on the B side, or the B keeper value |
| bDrive | output | 1 | B side is actively driven |
| contention | output | 1 | Both sides driven at once |

## Verification
The bench runs a reference model over long pseudo-random sequences of mode, strobe, enable and reset inputs on a 4-bit slice. Directed cases cover the following faults:
- A latch that keeps the newest input after the latch enable falls would break R4.
- An edge detector that loads on level would keep reloading under a held strobe and break R10.
- Swapped enable polarities would invert the drive flags and break R6.
- A keeper that tracks the path while the port is disabled would leak fresh data onto a bus that should hold its last word and break R7.
- A reset that missed the keepers would leave stale words showing on disabled ports and break R8.

// File: rtl/xcvrPkg.sv
package xcvrPkg;
  // Per-direction control handed from the control unit to a lane
  typedef struct packed {
    logic follow;   // transparent: output tracks input, storage tracks too
    logic capture;  // rising edge of the load strobe seen this cycle
    logic drive;    // effective output enable of the receiving port
  } laneCtl_t;
endpackage

// File: rtl/xcvrCtrl.sv
module xcvrCtrl
  import xcvrPkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     abLatchEn,
  input  logic     abClk,
  input  logic     abOutEn,
  input  logic     baLatchEn,
  input  logic     baClk,
  input  logic     baOutEnN,
  output laneCtl_t abCtl,
  output laneCtl_t baCtl,
  output logic     contention
);
  localparam int NDIR = 2;

  logic [NDIR-1:0] strobeNow;
  logic [NDIR-1:0] strobeRise;

  assign strobeNow = {baClk, abClk};

  genvar d;
  generate
    for (d = 0; d < NDIR; d++) begin : g_edge
      logic strobeLast;
      always_ff @(posedge clk) begin
        if (rst) strobeLast <= 1'b0;
        else     strobeLast <= strobeNow[d];
      end
      assign strobeRise[d] = strobeNow[d] & ~strobeLast;

      // R10: a captured edge cannot repeat on the next cycle
      a_r10_single_load : assert property (@(posedge clk) disable iff (rst)
        strobeRise[d] |=> !strobeRise[d]);
    end
  endgenerate

  always_comb begin
    abCtl.follow  = abLatchEn;
    abCtl.capture = strobeRise[0];
    abCtl.drive   = abOutEn;
    baCtl.follow  = baLatchEn;
    baCtl.capture = strobeRise[1];
    baCtl.drive   = ~baOutEnN;
  end

  assign contention = abCtl.drive & baCtl.drive;
endmodule

// File: rtl/xcvrLane.sv
module xcvrLane
  import xcvrPkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] dataIn,
  input  laneCtl_t         ctl,
  output logic [WIDTH-1:0] busOut
);
  localparam logic [WIDTH-1:0] ZERO = '0;

  logic [WIDTH-1:0] storeQ;
  logic [WIDTH-1:0] keepQ;
  logic [WIDTH-1:0] pathVal;

  // transparent bypass, otherwise stored word
  assign pathVal = ctl.follow ? dataIn : storeQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      storeQ <= ZERO;
    end else if (ctl.follow || ctl.capture) begin
      storeQ <= dataIn;
    end
  end

  // bus keeper remembers last actively driven word
  always_ff @(posedge clk) begin
    if (rst)            keepQ <= ZERO;
    else if (ctl.drive) keepQ <= pathVal;
  end

  assign busOut = ctl.drive ? pathVal : keepQ;

  a_r1_transparent : assert property (@(posedge clk) disable iff (rst)
    (ctl.follow && ctl.drive) |-> busOut == dataIn);

  a_r2_hold : assert property (@(posedge clk) disable iff (rst)
    (!ctl.follow && !ctl.capture) |=> $stable(storeQ));

  a_r3_edge_load : assert property (@(posedge clk) disable iff (rst)
    (ctl.capture && !ctl.follow) |=> storeQ == $past(dataIn));

  a_r7_keeper_holds : assert property (@(posedge clk) disable iff (rst)
    ($fell(ctl.drive) && !$past(rst)) |-> busOut == $past(busOut));
endmodule

// File: rtl/regBusXcvr.sv
module regBusXcvr
  import xcvrPkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  logic             abLatchEn,
  input  logic             abClk,
  input  logic             abOutEn,
  input  logic             baLatchEn,
  input  logic             baClk,
  input  logic             baOutEnN,
  output logic [WIDTH-1:0] aOut,
  output logic             aDrive,
  output logic [WIDTH-1:0] bOut,
  output logic             bDrive,
  output logic             contention
);
  laneCtl_t abCtl;
  laneCtl_t baCtl;

  xcvrCtrl u_ctrl (
    .clk(clk), .rst(rst),
    .abLatchEn(abLatchEn), .abClk(abClk), .abOutEn(abOutEn),
    .baLatchEn(baLatchEn), .baClk(baClk), .baOutEnN(baOutEnN),
    .abCtl(abCtl), .baCtl(baCtl), .contention(contention)
  );

  xcvrLane #(.WIDTH(WIDTH)) u_abLane (
    .clk(clk), .rst(rst), .dataIn(aIn), .ctl(abCtl), .busOut(bOut)
  );

  xcvrLane #(.WIDTH(WIDTH)) u_baLane (
    .clk(clk), .rst(rst), .dataIn(bIn), .ctl(baCtl), .busOut(aOut)
  );

  assign bDrive = abCtl.drive;
  assign aDrive = baCtl.drive;

  // R9: contention implies both ports are driven
  a_r9_contention : assert property (@(posedge clk) disable iff (rst)
    contention |-> (aDrive && bDrive));
endmodule

// File: tb/sim_regBusXcvr.sv
`timescale 1ns/1ps
module sim_regBusXcvr;
  localparam int W = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst;
  logic [W-1:0] aIn, bIn, aOut, bOut;
  logic abLatchEn, abClk, abOutEn, baLatchEn, baClk, baOutEnN;
  logic aDrive, bDrive, contention;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  regBusXcvr #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .aIn(aIn), .bIn(bIn),
    .abLatchEn(abLatchEn), .abClk(abClk), .abOutEn(abOutEn),
    .baLatchEn(baLatchEn), .baClk(baClk), .baOutEnN(baOutEnN),
    .aOut(aOut), .aDrive(aDrive), .bOut(bOut), .bDrive(bDrive),
    .contention(contention)
  );

  // reference state
  logic [W-1:0] mAB, mBA, kB, kA;
  logic pAB, pBA;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] pathAB();
    return abLatchEn ? aIn : mAB;
  endfunction
  function automatic logic [W-1:0] pathBA();
    return baLatchEn ? bIn : mBA;
  endfunction

  // advance one clock edge, updating the reference model
  task automatic tick();
    logic [W-1:0] nAB, nBA, nkB, nkA;
    logic rAB, rBA;
    rAB = abClk & ~pAB;
    rBA = baClk & ~pBA;
    nAB = (abLatchEn || rAB) ? aIn : mAB;
    nBA = (baLatchEn || rBA) ? bIn : mBA;
    nkB = abOutEn ? pathAB() : kB;
    nkA = !baOutEnN ? pathBA() : kA;
    @(posedge clk);
    #1;
    if (rst) begin
      mAB = '0; mBA = '0; kB = '0; kA = '0; pAB = 0; pBA = 0;
    end else begin
      mAB = nAB; mBA = nBA; kB = nkB; kA = nkA; pAB = abClk; pBA = baClk;
    end
  endtask

  // compare outputs against the reference model
  task automatic compareAll();
    string tb, ta;
    #0.5;
    if (!abOutEn) tb = "R7 b keeper";
    else if (abLatchEn) tb = "R1 b transparent";
    else tb = "R2/R3 b stored";
    if (baOutEnN) ta = "R7 a keeper";
    else if (baLatchEn) ta = "R5 a transparent";
    else ta = "R5 a stored";
    check(tb, bOut, abOutEn ? pathAB() : kB);
    check(ta, aOut, !baOutEnN ? pathBA() : kA);
    check("R6 bDrive", bDrive, abOutEn);
    check("R6 aDrive", aDrive, !baOutEnN);
    check("R9 contention", contention, abOutEn & !baOutEnN);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1; aIn = 4'h5; bIn = 4'hA;
    abLatchEn = 1; abClk = 1; abOutEn = 0;
    baLatchEn = 1; baClk = 1; baOutEnN = 1;
    mAB = 'x; mBA = 'x; kB = 'x; kA = 'x; pAB = 0; pBA = 0;
    tick(); tick();
    // R8: after reset, disabled ports show cleared keepers
    check("R8 bOut keeper", bOut, 0);
    check("R8 aOut keeper", aOut, 0);
    abLatchEn = 0; baLatchEn = 0; abClk = 0; baClk = 0;
    abOutEn = 1; baOutEnN = 0;
    #0.5;
    check("R8 stored ab", bOut, 0);
    check("R8 stored ba", aOut, 0);
    rst = 0;
    tick();

    // R4: latch falls, stored word is last transparent input
    abLatchEn = 1; aIn = 4'h6; tick();
    abLatchEn = 0; aIn = 4'h9; #0.5;
    check("R4 latch fall", bOut, 4'h6);
    tick();
    check("R4 latch fall held", bOut, 4'h6);
    baLatchEn = 1; bIn = 4'h3; tick();
    baLatchEn = 0; bIn = 4'hC; #0.5;
    check("R5 latch fall", aOut, 4'h3);

    // R10: held strobe loads once
    aIn = 4'h2; abClk = 1; tick();
    check("R10 first load", bOut, 4'h2);
    aIn = 4'hE; tick(); tick();
    check("R10 no reload", bOut, 4'h2);
    abClk = 0; tick();
    check("R2 hold", bOut, 4'h2);

    // R7: disable then change input; keeper shows last driven
    abOutEn = 0; abLatchEn = 1; aIn = 4'h1; tick();
    check("R7 keeper", bOut, 4'h2);
    abLatchEn = 0;

    // pseudo-random sweep against the model
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] r;
      r = 16'($urandom);
      rst = (r[15:10] == 0);
      abLatchEn = r[0] & r[1];
      baLatchEn = r[2] & r[3];
      abClk = r[4]; baClk = r[5];
      abOutEn = r[6]; baOutEnN = r[7];
      aIn = r[11:8]; bIn = 4'(r[15:12] ^ r[3:0]);
      compareAll();
      tick();
    end
    rst = 0;
    compareAll();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule